// File: doc/BRIEF.md
# Packet-organized OTP read controller

This block is a register-mapped reader for a one-time-programmable word array that holds variable-length packets. Each packet starts with a header word, whose size field `S` is in bits 15:8. The header is followed by `S + 1` payload words, so a packet spans `S + 2` words. The first header whose size field is zero ends the programmed region.

Software starts a read in three steps. It puts a word address in bits 31:16 of the mode register. It then writes the control register with bit 6 set. Finally it polls bit 6 of the status register until that bit falls.

The controller does not fetch the requested word itself. It walks the headers from word 0 until it finds the packet whose span holds the requested address. It then copies that packet into internal temporary storage. After the copy, software reads the header from the header register. It walks the payload by writing a start index to the payload-index register and reading the payload-data register repeatedly.

A behavioural model of the fuse array is part of the block. The model is filled at start-up from a parameterised image and has a one-cycle read latency.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset, status, header, payload-index and payload-data reads all return 0.
- R2: The register byte offsets are:
  - control 0x00
  - mode 0x04
  - payload index 0x08
  - status 0x0C
  - header 0x20
  - payload data 0x24

  A read strobe returns its data with `bus_rvalid` high on the following cycle. The mode register reads back every bit written to it, and bits 31:16 are the requested word address.
- R3: A control write with bit 6 set, made while idle, starts a packet read. Status bit 6 reads 1 from the cycle after that write until the copy completes, and then reads 0. Control bit 6 always reads back 0.
- R4: Any requested address in the half-open span [start(p), start(p) + S(p) + 2) loads packet p, and the header register returns p's header word.
- R5: Starting a read sets the payload index to 0. Writing value k to the payload index makes the next data read return payload word k. Each data read returns the word at the current index and then increments the index.
- R6: A data read whose index is not below `S + 1` returns 0 and leaves the index unchanged.
- R7: A read is "not found" when the walk meets a zero-size header, a packet that would run past the end of the array, or the end of the array itself, before reaching the requested address. A not-found read ends with header 0 and an empty payload.
- R8: A control write with bit 6 set is ignored while status bit 6 is 1. The pending read completes using the address that was latched when it started.
- R9: The default array image holds `PKT_COUNT` packets placed back to back from word 0, and every other word is 0. For packet p:
  - the size is `S(p) = ((5p + IMG_SEED) mod IMG_MAX_SZ) + 1`;
  - the header is `{16'hC0DE ^ p, S(p), p}`;
  - payload word j is `{8'hD0 ^ p, j, p ^ 8'h5A, j ^ 8'hC3}`.
- R10: The busy period lasts no more than `2 * DEPTH + 4` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
A wrong walk position or size sum shows up as the header of a neighbouring packet. This is easiest to see when the requested address is on the first or last word of a packet's span, and it is visible on the first header read after status falls. A payload copy that is off by one word shows up on the very first data read after the index is rewound. An index that runs past the payload shows up as a nonzero value, or as a changed index readback, on the data read that follows the last payload word. A stuck or runaway walk keeps status bit 6 high beyond its bound, and the watchdog or the busy-length check catches it.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_MODE  = 8'h04;
  localparam logic [7:0] OFF_PIDX  = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h0C;
  localparam logic [7:0] OFF_HDR   = 8'h20;
  localparam logic [7:0] OFF_PDATA = 8'h24;
  localparam int         GO_BIT    = 6;
  localparam int         BUSY_BIT  = 6;
  localparam int         SZ_LSB    = 8;

  typedef enum logic [2:0] {
    SK_IDLE,
    SK_HREQ,
    SK_HWAIT,
    SK_PREQ,
    SK_PWAIT
  } seek_state_e;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int DEPTH      = 2816,
  parameter int AW         = 12,
  parameter int PKT_COUNT  = 10,
  parameter int IMG_SEED   = 3,
  parameter int IMG_MAX_SZ = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [31:0]   q
);
  logic [31:0] mem [0:DEPTH-1];

  // Image fill: packets back to back from word 0, rest zero.
  initial begin
    int pos;
    int sz;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    pos = 0;
    for (int p = 0; p < PKT_COUNT; p++) begin
      sz = ((p * 5 + IMG_SEED) % IMG_MAX_SZ) + 1;
      if (pos + sz + 2 <= DEPTH) begin
        mem[AW'(pos)] = {16'hC0DE ^ 16'(p), 8'(sz), 8'(p)};
        for (int j = 0; j <= sz; j++)
          mem[AW'(pos + 1 + j)] = {8'hD0 ^ 8'(p), 8'(j), 8'(p) ^ 8'h5A, 8'(j) ^ 8'hC3};
      end
      pos = pos + sz + 2;
    end
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[addr];
  end
endmodule

// File: rtl/otp_pkt_buffer.sv
module otp_pkt_buffer #(
  parameter int ENTRIES = 256,
  parameter int IW      = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] raddr,
  output logic [31:0]   rq
);
  logic [31:0] mem [0:ENTRIES-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq <= mem[raddr];
  end
endmodule

// File: rtl/otp_pkt_seeker.sv
module otp_pkt_seeker
  import otp_pkt_pkg::*;
#(
  parameter int DEPTH = 2816,
  parameter int AW    = 12,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [15:0]   target,
  output logic          arr_en,
  output logic [AW-1:0] arr_addr,
  input  logic [31:0]   arr_q,
  output logic          buf_we,
  output logic [PW-1:0] buf_waddr,
  output logic [31:0]   buf_wdata,
  output logic          busy,
  output logic [31:0]   hdr,
  output logic [PW:0]   plen
);
  localparam int POS_W = 17;
  localparam logic [POS_W-1:0] DEPTH_P = POS_W'(DEPTH);

  seek_state_e      st;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] tgt;
  logic [PW:0]      cnt;
  logic [7:0]       sz_f;
  logic [POS_W-1:0] span;
  logic [POS_W-1:0] fetch;

  assign sz_f  = arr_q[SZ_LSB +: 8];
  assign span  = pos + POS_W'(sz_f) + POS_W'(2);
  assign fetch = pos + POS_W'(1) + POS_W'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SK_IDLE;
      pos  <= '0;
      tgt  <= '0;
      cnt  <= '0;
      hdr  <= '0;
      plen <= '0;
    end else begin
      case (st)
        SK_IDLE: if (start) begin
          pos <= '0;
          tgt <= POS_W'(target);
          st  <= SK_HREQ;
        end
        SK_HREQ: if (pos >= DEPTH_P) begin
          hdr  <= '0;
          plen <= '0;
          st   <= SK_IDLE;
        end else begin
          st <= SK_HWAIT;
        end
        SK_HWAIT: if (sz_f == 8'd0 || span > DEPTH_P) begin
          hdr  <= '0;
          plen <= '0;
          st   <= SK_IDLE;
        end else if (tgt < span) begin
          hdr  <= arr_q;
          plen <= (PW+1)'(sz_f) + (PW+1)'(1);
          cnt  <= '0;
          st   <= SK_PREQ;
        end else begin
          pos <= span;
          st  <= SK_HREQ;
        end
        SK_PREQ: st <= SK_PWAIT;
        SK_PWAIT: begin
          cnt <= cnt + 1'b1;
          st  <= (cnt == plen - 1'b1) ? SK_IDLE : SK_PREQ;
        end
        default: st <= SK_IDLE;
      endcase
    end
  end

  assign arr_en    = (st == SK_HREQ && pos < DEPTH_P) || st == SK_PREQ;
  assign arr_addr  = (st == SK_PREQ) ? fetch[AW-1:0] : pos[AW-1:0];
  assign buf_we    = (st == SK_PWAIT);
  assign buf_waddr = cnt[PW-1:0];
  assign buf_wdata = arr_q;
  assign busy      = (st != SK_IDLE);
endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader
  import otp_pkt_pkg::*;
#(
  parameter int ARR_BYTES  = 11264,
  parameter int MAX_PAY    = 256,
  parameter int ADDR_W     = 8,
  parameter int PKT_COUNT  = 10,
  parameter int IMG_SEED   = 3,
  parameter int IMG_MAX_SZ = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int DEPTH      = ARR_BYTES / 4;
  localparam int AW         = $clog2(DEPTH);
  localparam int PW         = $clog2(MAX_PAY);
  localparam int BUSY_LIMIT = 2 * DEPTH + 4;

  logic          arr_en;
  logic [AW-1:0] arr_addr;
  logic [31:0]   arr_q;
  logic          buf_we;
  logic [PW-1:0] buf_waddr;
  logic [31:0]   buf_wdata;
  logic [31:0]   buf_q;
  logic          busy;
  logic [31:0]   hdr;
  logic [PW:0]   plen;
  logic [PW:0]   pidx;
  logic [31:0]   mode_q;
  logic          start_acc;
  logic          hit_ctrl, hit_mode, hit_pidx, hit_stat, hit_hdr, hit_pdata;
  logic [31:0]   reg_q;
  logic          sel_data_q;
  logic          zero_q;

  assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_mode  = (bus_addr == ADDR_W'(OFF_MODE));
  assign hit_pidx  = (bus_addr == ADDR_W'(OFF_PIDX));
  assign hit_stat  = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_hdr   = (bus_addr == ADDR_W'(OFF_HDR));
  assign hit_pdata = (bus_addr == ADDR_W'(OFF_PDATA));

  assign start_acc = bus_wr && hit_ctrl && bus_wdata[GO_BIT] && !busy;

  otp_fuse_array #(
    .DEPTH(DEPTH), .AW(AW), .PKT_COUNT(PKT_COUNT),
    .IMG_SEED(IMG_SEED), .IMG_MAX_SZ(IMG_MAX_SZ)
  ) u_array (
    .clk(clk), .en(arr_en), .addr(arr_addr), .q(arr_q)
  );

  otp_pkt_seeker #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_seek (
    .clk(clk), .rst(rst), .start(start_acc), .target(mode_q[31:16]),
    .arr_en(arr_en), .arr_addr(arr_addr), .arr_q(arr_q),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .busy(busy), .hdr(hdr), .plen(plen)
  );

  otp_pkt_buffer #(.ENTRIES(MAX_PAY), .IW(PW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(pidx[PW-1:0]), .rq(buf_q)
  );

  // Mode register and payload index.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      pidx   <= '0;
    end else begin
      if (bus_wr && hit_mode) mode_q <= bus_wdata;
      if (start_acc)
        pidx <= '0;
      else if (bus_wr && hit_pidx)
        pidx <= bus_wdata[PW:0];
      else if (bus_rd && hit_pdata && pidx < plen)
        pidx <= pidx + 1'b1;
    end
  end

  // Registered read path; payload words come from the buffer output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      reg_q      <= '0;
      sel_data_q <= 1'b0;
      zero_q     <= 1'b1;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        sel_data_q <= hit_pdata;
        zero_q     <= (pidx >= plen);
        reg_q      <= '0;
        if (hit_mode) reg_q <= mode_q;
        if (hit_pidx) reg_q <= 32'(pidx);
        if (hit_stat) reg_q <= 32'(busy) << BUSY_BIT;
        if (hit_hdr)  reg_q <= hdr;
      end
    end
  end

  assign bus_rdata = sel_data_q ? (zero_q ? 32'd0 : buf_q) : reg_q;
endmodule

// File: rtl/otp_pkt_reader_chk.sv
module otp_pkt_reader_chk
  import otp_pkt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PW         = 8,
  parameter int BUSY_LIMIT = 5636
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              start_acc,
  input logic              busy,
  input logic [31:0]       hdr,
  input logic [PW:0]       plen,
  input logic [PW:0]       pidx
);
  localparam int CW = $clog2(BUSY_LIMIT + 2) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 1'b1;
  end

  logic data_beyond;
  assign data_beyond = bus_rd && !bus_wr && (bus_addr == ADDR_W'(OFF_PDATA)) && (pidx >= plen);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> busy);

  p_busy_origin_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_acc));

  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_beyond_zero_r6: assert property (@(posedge clk) disable iff (rst)
    data_beyond |=> (bus_rdata == 32'd0));

  p_no_advance_r6: assert property (@(posedge clk) disable iff (rst)
    data_beyond |=> (pidx == $past(pidx)));

  p_hdr_size_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && hdr != 32'd0) |-> (hdr[SZ_LSB +: 8] != 8'd0));

  p_plen_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (plen == ((hdr == 32'd0) ? '0 : (PW+1)'(hdr[SZ_LSB +: 8]) + (PW+1)'(1))));

  p_busy_bound_r10: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CW'(BUSY_LIMIT));
endmodule

bind otp_pkt_reader otp_pkt_reader_chk #(
  .ADDR_W(ADDR_W), .PW(PW), .BUSY_LIMIT(BUSY_LIMIT)
) u_chk (.*);

// File: tb/otp_pkt_reader_tb.sv
module otp_pkt_reader_tb;
  localparam int PKT_COUNT  = 10;
  localparam int IMG_SEED   = 3;
  localparam int IMG_MAX_SZ = 6;
  localparam int DEPTH      = 2816;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  otp_pkt_reader u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // Reference image per R9
  function automatic int bsz(int p);
    return ((p * 5 + IMG_SEED) % IMG_MAX_SZ) + 1;
  endfunction
  function automatic int bstart(int p);
    int s = 0;
    for (int i = 0; i < p; i++) s += bsz(i) + 2;
    return s;
  endfunction
  function automatic logic [31:0] bhdr(int p);
    return {16'hC0DE ^ 16'(p), 8'(bsz(p)), 8'(p)};
  endfunction
  function automatic logic [31:0] bpay(int p, int j);
    return {8'hD0 ^ 8'(p), 8'(j), 8'(p) ^ 8'h5A, 8'(j) ^ 8'hC3};
  endfunction
  function automatic int bfind(int t);
    for (int p = 0; p < PKT_COUNT; p++)
      if (t >= bstart(p) && t < bstart(p + 1)) return p;
    return -1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    if (!bus_rvalid) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 actual=rvalid 0 expected=rvalid 1");
    end
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(8'h0C, s);
      if (s[6] == 1'b0) return;
    end
    check("R10 busy never cleared", s, 32'd0);
  endtask

  task automatic run_packet(int t, bit rand_off);
    logic [31:0] d;
    int p = bfind(t);
    bus_write(8'h04, {16'(t), 16'h00A5});
    bus_write(8'h00, 32'h40);
    bus_read(8'h0C, d);
    check("R3 busy after start", d, 32'h40);
    wait_idle();
    bus_read(8'h00, d);
    check("R3 control bit reads 0", d, 32'd0);
    bus_read(8'h20, d);
    if (p < 0) begin
      check("R7 not-found header", d, 32'd0);
      bus_read(8'h24, d);
      check("R7 not-found data", d, 32'd0);
      bus_read(8'h08, d);
      check("R6 index stays at 0", d, 32'd0);
      return;
    end
    check("R4 header of located packet", d, bhdr(p));
    if (rand_off) begin
      int k = int'($urandom % 32'(bsz(p) + 1));
      bus_write(8'h08, 32'(k));
      bus_read(8'h24, d);
      check("R5 indexed payload word", d, bpay(p, k));
      bus_read(8'h24, d);
      check("R5 next payload word", d, (k < bsz(p)) ? bpay(p, k + 1) : 32'd0);
    end else begin
      bus_write(8'h08, 32'd0);
      for (int j = 0; j <= bsz(p); j++) begin
        bus_read(8'h24, d);
        check("R5 payload sequence", d, bpay(p, j));
      end
      for (int j = 0; j < 2; j++) begin
        bus_read(8'h24, d);
        check("R6 read beyond payload", d, 32'd0);
      end
      bus_read(8'h08, d);
      check("R6 index saturated", d, 32'(bsz(p) + 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int total;
    void'($urandom(32'd1234));
    total = bstart(PKT_COUNT);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(8'h0C, d); check("R1 status", d, 32'd0);
    bus_read(8'h20, d); check("R1 header", d, 32'd0);
    bus_read(8'h08, d); check("R1 index", d, 32'd0);
    bus_read(8'h24, d); check("R1 data", d, 32'd0);

    // R2 mode register keeps all bits
    bus_write(8'h04, 32'h0003_5A5A);
    bus_read(8'h04, d); check("R2 mode readback", d, 32'h0003_5A5A);

    // R4 span edges, R7 terminator and out of range
    run_packet(0, 1'b0);
    run_packet(bstart(3), 1'b0);
    run_packet(bstart(4) - 1, 1'b0);
    run_packet(bstart(PKT_COUNT) - 1, 1'b0);
    run_packet(total, 1'b0);
    run_packet(total + 1, 1'b0);
    run_packet(DEPTH + 5, 1'b0);
    run_packet(16'hFFFF, 1'b0);

    // R8 second start while busy is ignored
    bus_write(8'h04, {16'(bstart(2)), 16'h0});
    bus_write(8'h00, 32'h40);
    bus_write(8'h04, {16'(bstart(7)), 16'h0});
    bus_write(8'h00, 32'h40);
    wait_idle();
    bus_read(8'h20, d); check("R8 header from first request", d, bhdr(2));
    bus_read(8'h0C, d); check("R8 no restart after done", d, 32'd0);

    // Random targets, R4/R5/R6/R7
    for (int i = 0; i < 30; i++) begin
      int t = int'($urandom % 32'(total + 8));
      run_packet(t, i[0]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule